// File: doc/BRIEF.md
# Host-to-Processor Mailbox Interface

This block is a two-way data mailbox between an external host on an 8-bit register bus and a processor on a 24-bit register bus. Each direction holds one 24-bit word. The host moves a word as three byte registers, high, middle and low. The processor moves a word as one full-width register. Both sides can poll full and empty status bits. Two host flags and two processor flags cross to the other side and are read-only there. The processor side can also be driven by interrupt requests that are gated by enable bits in its control register.

Both buses share one clock. Writes are single-cycle strobes. Read data is combinational from the selected register, and a read strobe only matters where a read has a side effect. A word sent toward a side that is still full is discarded. The sender sees this only because the full status stays set.

Top module: `hpm_top`

## Requirements
- R1: After reset, host status reads 8'h02 (transmit-empty at bit 1 set, receive-full at bit 0 clear). Processor status reads 24'h000002. Both control registers read 0 and both interrupt outputs are 0.
- R2: The host writes bytes at host address 2 (bits 23:16) and address 3 (bits 15:8). A host write at address 4 (bits 7:0) commits the assembled word to the processor receive register (processor address 3). It also sets processor status bit 0 and clears host status bit 1.
- R3: A processor read of address 3 while processor status bit 0 is set clears that bit and sets host status bit 1 again.
- R4: A processor write to address 2 while host status bit 0 is clear places the word in the host byte registers at addresses 2, 3 and 4. It also sets host status bit 0 and clears processor status bit 1.
- R5: A host read of address 4 clears host status bit 0 and sets processor status bit 1. Host reads of addresses 2 and 3 leave both bits unchanged.
- R6: A host write at address 4 while processor status bit 0 is set is ignored. The processor receive register keeps its old word.
- R7: A processor write to address 2 while host status bit 0 is set is ignored. The host byte registers keep their old word.
- R8: Processor control bits 4:3 (address 1) are writable flags and appear in host status bits 4:3. Host writes to host status (address 1) change nothing.
- R9: Host control bits 4:3 (address 0) are writable flags and appear in processor status bits 4:3 (address 0).
- R10: `irq_rx_full` equals processor status bit 0 gated by processor control bit 0. `irq_tx_empty` equals processor status bit 1 gated by processor control bit 1.
- R11: When a send and the matching take fall in the same cycle, the send is judged on the full state before that edge. A host low-byte write and a processor receive read in one cycle, starting from full, leave the receive side empty and drop the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 3 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| p_wr | input | 1 | Processor write strobe |
| p_rd | input | 1 | Processor read strobe |
| p_addr | input | 2 | Processor register address |
| p_wdata | input | 24 | Processor write data |
| p_rdata | output | 24 | Processor read data |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |

## Verification
The bench fills each direction a second time before the first word is drained. A design that let the second word through would return it in place of the first. It reads the high and middle host bytes on their own, so a design that cleared receive-full on any byte read would show the word as consumed too early. It also sends a host low byte and takes the processor word in the same cycle. A design that judged fullness after the take would keep the new word and leave receive-full set. Finally, it writes the host status address and toggles the interrupt enables, to catch flag bits that the wrong side can write and interrupts that ignore their enable.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  // processor register addresses
  localparam int P_STAT = 0;
  localparam int P_CTRL = 1;
  localparam int P_TX   = 2;
  localparam int P_RX   = 3;
  // host register addresses; byte registers start at H_BYTE0 (high byte first)
  localparam int H_CTRL  = 0;
  localparam int H_STAT  = 1;
  localparam int H_BYTE0 = 2;
  // fixed bit positions
  localparam int B_RXF   = 0;
  localparam int B_TXE   = 1;
  localparam int B_FLGLO = 3;
  localparam int B_FLGHI = 4;

  // status byte layout shared by both sides
  function automatic logic [7:0] pack_status(logic rxf, logic txe, logic [1:0] flags);
    logic [7:0] s;
    s = '0;
    s[B_RXF] = rxf;
    s[B_TXE] = txe;
    s[B_FLGHI:B_FLGLO] = flags;
    return s;
  endfunction

  function automatic logic [7:0] pack_ctrl(logic [1:0] en, logic [1:0] flags);
    logic [7:0] c;
    c = '0;
    c[1:0] = en;
    c[B_FLGHI:B_FLGLO] = flags;
    return c;
  endfunction
endpackage

// File: rtl/hpm_h2p_chan.sv
module hpm_h2p_chan #(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8,
  localparam int NB = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     byte_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              take,
  output logic [WORD_W-1:0] word,
  output logic              full,
  output logic              commit_ev,
  output logic              drop_ev
);
  logic [BYTE_W-1:0] stage [NB-1];
  logic [WORD_W-1:0] assembled;

  for (genvar i = 0; i < NB - 1; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)          stage[i] <= '0;
      else if (byte_we[i]) stage[i] <= wdata;
    end
    assign assembled[WORD_W-1-i*BYTE_W -: BYTE_W] = stage[i];
  end
  assign assembled[BYTE_W-1:0] = wdata;

  assign commit_ev = byte_we[NB-1] && !full;
  assign drop_ev   = byte_we[NB-1] && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      full <= 1'b0;
    end else if (commit_ev) begin
      word <= assembled;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/hpm_p2h_chan.sv
module hpm_p2h_chan #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              take,
  output logic [WORD_W-1:0] word,
  output logic              full,
  output logic              load_ev,
  output logic              drop_ev
);
  assign load_ev = load && !full;
  assign drop_ev = load && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      full <= 1'b0;
    end else if (load_ev) begin
      word <= load_word;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/hpm_top.sv
module hpm_top
  import hpm_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8,
  parameter int HA_W   = 3,
  parameter int PA_W   = 2,
  localparam int NB    = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [HA_W-1:0]   h_addr,
  input  logic [BYTE_W-1:0] h_wdata,
  output logic [BYTE_W-1:0] h_rdata,
  input  logic              p_wr,
  input  logic              p_rd,
  input  logic [PA_W-1:0]   p_addr,
  input  logic [WORD_W-1:0] p_wdata,
  output logic [WORD_W-1:0] p_rdata,
  output logic              irq_rx_full,
  output logic              irq_tx_empty
);
  logic [1:0]        p_en, p_flags, h_flags;
  logic [NB-1:0]     h_byte_hit;
  logic [NB-1:0]     h_byte_we;
  logic [WORD_W-1:0] p_rx_word, h_rx_word;
  logic              p_rxf, h_rxf;
  logic              h2p_commit, h2p_drop, p2h_load, p2h_drop;
  logic              p_rx_take, h_low_take, p_tx_load;
  logic              p_txe, h_txe;
  logic [7:0]        p_stat8, h_stat8;

  for (genvar i = 0; i < NB; i++) begin : g_hdec
    assign h_byte_hit[i] = (h_addr == HA_W'(H_BYTE0 + i));
    assign h_byte_we[i]  = h_wr && h_byte_hit[i];
  end

  assign p_rx_take  = p_rd && (p_addr == PA_W'(P_RX));
  assign p_tx_load  = p_wr && (p_addr == PA_W'(P_TX));
  assign h_low_take = h_rd && h_byte_hit[NB-1];

  hpm_h2p_chan #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_h2p (
    .clk(clk), .rst_n(rst_n), .byte_we(h_byte_we), .wdata(h_wdata),
    .take(p_rx_take), .word(p_rx_word), .full(p_rxf),
    .commit_ev(h2p_commit), .drop_ev(h2p_drop)
  );

  hpm_p2h_chan #(.WORD_W(WORD_W)) u_p2h (
    .clk(clk), .rst_n(rst_n), .load(p_tx_load), .load_word(p_wdata),
    .take(h_low_take), .word(h_rx_word), .full(h_rxf),
    .load_ev(p2h_load), .drop_ev(p2h_drop)
  );

  // control registers on both sides
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_en    <= '0;
      p_flags <= '0;
      h_flags <= '0;
    end else begin
      if (p_wr && p_addr == PA_W'(P_CTRL)) begin
        p_en    <= p_wdata[1:0];
        p_flags <= p_wdata[B_FLGHI:B_FLGLO];
      end
      if (h_wr && h_addr == HA_W'(H_CTRL))
        h_flags <= h_wdata[B_FLGHI:B_FLGLO];
    end
  end

  assign p_txe   = !h_rxf;
  assign h_txe   = !p_rxf;
  assign p_stat8 = pack_status(p_rxf, p_txe, h_flags);
  assign h_stat8 = pack_status(h_rxf, h_txe, p_flags);

  assign irq_rx_full  = p_rxf && p_en[0];
  assign irq_tx_empty = p_txe && p_en[1];

  always_comb begin
    p_rdata = '0;
    case (p_addr)
      PA_W'(P_STAT): p_rdata = WORD_W'(p_stat8);
      PA_W'(P_CTRL): p_rdata = WORD_W'(pack_ctrl(p_en, p_flags));
      PA_W'(P_RX):   p_rdata = p_rx_word;
      default:       p_rdata = '0;
    endcase
  end

  always_comb begin
    h_rdata = '0;
    if (h_addr == HA_W'(H_CTRL)) h_rdata = pack_ctrl(2'b00, h_flags);
    if (h_addr == HA_W'(H_STAT)) h_rdata = h_stat8;
    for (int i = 0; i < NB; i++)
      if (h_byte_hit[i]) h_rdata = h_rx_word[WORD_W-1-i*BYTE_W -: BYTE_W];
  end
endmodule

// File: rtl/hpm_chk.sv
module hpm_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h2p_commit,
  input logic              h2p_drop,
  input logic              p2h_load,
  input logic              p2h_drop,
  input logic              p_rx_take,
  input logic              h_low_take,
  input logic              p_rxf,
  input logic              h_rxf,
  input logic [WORD_W-1:0] p_rx_word,
  input logic [WORD_W-1:0] h_rx_word,
  input logic [1:0]        p_en,
  input logic              irq_rx_full,
  input logic              irq_tx_empty
);
  p_commit_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h2p_commit |=> p_rxf);
  p_take_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rx_take && p_rxf) |=> !p_rxf);
  p_load_sets_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    p2h_load |=> h_rxf);
  p_low_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_low_take && h_rxf) |=> !h_rxf);
  p_h2p_drop_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h2p_drop |=> $stable(p_rx_word));
  p_p2h_drop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    p2h_drop |=> $stable(h_rx_word));
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_en[0] |-> !irq_rx_full) and (!p_en[1] |-> !irq_tx_empty));
  p_no_commit_when_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    p_rxf |-> !h2p_commit);
endmodule

bind hpm_top hpm_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .h2p_commit(h2p_commit), .h2p_drop(h2p_drop),
  .p2h_load(p2h_load), .p2h_drop(p2h_drop),
  .p_rx_take(p_rx_take), .h_low_take(h_low_take),
  .p_rxf(p_rxf), .h_rxf(h_rxf),
  .p_rx_word(p_rx_word), .h_rx_word(h_rx_word),
  .p_en(p_en), .irq_rx_full(irq_rx_full), .irq_tx_empty(irq_tx_empty)
);

// File: tb/hpm_top_tb_top.sv
module hpm_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr = 0, h_rd = 0, p_wr = 0, p_rd = 0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic [1:0] p_addr = '0;
  logic [23:0] p_wdata = '0, p_rdata;
  logic irq_rx_full, irq_tx_empty;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hpm_top dut_i (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .p_wr(p_wr), .p_rd(p_rd),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .irq_rx_full(irq_rx_full), .irq_tx_empty(irq_tx_empty)
  );

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic hread(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); h_rd = 1; h_addr = a; #1 d = h_rdata;
    @(negedge clk); h_rd = 0;
  endtask

  task automatic pwrite(logic [1:0] a, logic [23:0] d);
    @(negedge clk); p_wr = 1; p_addr = a; p_wdata = d;
    @(negedge clk); p_wr = 0;
  endtask

  task automatic pread(logic [1:0] a, output logic [23:0] d);
    @(negedge clk); p_rd = 1; p_addr = a; #1 d = p_rdata;
    @(negedge clk); p_rd = 0;
  endtask

  task automatic hsend(logic [23:0] w);
    hwrite(3'd2, w[23:16]); hwrite(3'd3, w[15:8]); hwrite(3'd4, w[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] h; logic [23:0] p;
    hread(3'd1, h); check("R1 host status", 24'(h), 24'h02);
    pread(2'd0, p); check("R1 proc status", p, 24'h2);
    pread(2'd1, p); check("R1 proc ctrl", p, 24'h0);
    hread(3'd0, h); check("R1 host ctrl", 24'(h), 24'h0);
    check("R1 irqs", {22'b0, irq_rx_full, irq_tx_empty}, 24'h0);
  endtask

  task automatic t_h2p;
    logic [7:0] h; logic [23:0] p;
    hsend(24'hABCDEF);
    pread(2'd0, p); check("R2 proc rx full", p, 24'h3);
    hread(3'd1, h); check("R2 host tx not empty", 24'(h), 24'h00);
    pread(2'd3, p); check("R2 word", p, 24'hABCDEF);
    pread(2'd0, p); check("R3 proc rx cleared", p, 24'h2);
    hread(3'd1, h); check("R3 host tx empty", 24'(h), 24'h02);
  endtask

  task automatic t_h2p_overrun;
    logic [23:0] p;
    hsend(24'h112233);
    hsend(24'h445566);
    pread(2'd3, p); check("R6 first word kept", p, 24'h112233);
    pread(2'd0, p); check("R6 rx empty after take", p, 24'h2);
  endtask

  task automatic t_p2h;
    logic [7:0] h; logic [23:0] p;
    pwrite(2'd2, 24'h123456);
    hread(3'd1, h); check("R4 host rx full", 24'(h), 24'h03);
    pread(2'd0, p); check("R4 proc tx not empty", p, 24'h0);
    hread(3'd2, h); check("R4 high byte", 24'(h), 24'h12);
    hread(3'd3, h); check("R4 mid byte", 24'(h), 24'h34);
    hread(3'd1, h); check("R5 high/mid reads keep full", 24'(h), 24'h03);
    hread(3'd4, h); check("R4 low byte", 24'(h), 24'h56);
    hread(3'd1, h); check("R5 low read clears full", 24'(h), 24'h02);
    pread(2'd0, p); check("R5 proc tx empty", p, 24'h2);
  endtask

  task automatic t_p2h_overrun;
    logic [7:0] h;
    pwrite(2'd2, 24'hA1B2C3);
    pwrite(2'd2, 24'hD4E5F6);
    hread(3'd2, h); check("R7 high kept", 24'(h), 24'hA1);
    hread(3'd4, h); check("R7 low kept", 24'(h), 24'hC3);
  endtask

  task automatic t_flags;
    logic [7:0] h; logic [23:0] p;
    pwrite(2'd1, 24'h18);
    hread(3'd1, h); check("R8 flags in host status", 24'(h), 24'h1A);
    pread(2'd1, p); check("R8 proc ctrl readback", p, 24'h18);
    hwrite(3'd1, 8'h00);
    hread(3'd1, h); check("R8 host status write ignored", 24'(h), 24'h1A);
    hwrite(3'd0, 8'h08);
    pread(2'd0, p); check("R9 flag in proc status", p, 24'h0A);
    hread(3'd0, h); check("R9 host ctrl readback", 24'(h), 24'h08);
    pwrite(2'd1, 24'h0); hwrite(3'd0, 8'h00);
    pread(2'd0, p); check("R9 flags cleared", p, 24'h2);
  endtask

  task automatic t_irq;
    logic [23:0] p;
    pwrite(2'd1, 24'h3);
    check("R10 tx irq on, rx off", {22'b0, irq_rx_full, irq_tx_empty}, 24'h1);
    hsend(24'h000777);
    check("R10 rx irq on", {22'b0, irq_rx_full, irq_tx_empty}, 24'h3);
    pwrite(2'd1, 24'h0);
    check("R10 both masked", {22'b0, irq_rx_full, irq_tx_empty}, 24'h0);
    pwrite(2'd1, 24'h1);
    check("R10 rx only", {22'b0, irq_rx_full, irq_tx_empty}, 24'h2);
    pread(2'd3, p);
    check("R10 rx irq drops after take", {22'b0, irq_rx_full, irq_tx_empty}, 24'h0);
    pwrite(2'd1, 24'h0);
  endtask

  task automatic t_same_cycle;
    logic [23:0] p;
    hsend(24'h0000AA);
    hwrite(3'd2, 8'h99); hwrite(3'd3, 8'h88);
    @(negedge clk);
    h_wr = 1; h_addr = 3'd4; h_wdata = 8'h77;
    p_rd = 1; p_addr = 2'd3; #1 p = p_rdata;
    check("R11 take returns old word", p, 24'h0000AA);
    @(negedge clk); h_wr = 0; p_rd = 0;
    pread(2'd0, p); check("R11 send dropped, rx empty", p, 24'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_h2p;
    t_h2p_overrun;
    t_p2h;
    t_p2h_overrun;
    t_flags;
    t_irq;
    t_same_cycle;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule